// File: doc/BRIEF.md
# Eight-bit ALU with status flags

This unit performs the byte arithmetic and logic of a small eight-bit processor and works out, for each operation, the next value of an eight-bit status byte. The caller presents an operation code, one or two operand bytes, a six-bit constant, a register-pair selector and the current status byte. One clock later the unit presents the result, a write strobe and the next status byte. Fetching operands from a register file and decoding instructions belong to the caller.

The status byte holds, from bit 7 down to bit 0: interrupt enable (I), transfer bit (T), half carry (H), sign (S), overflow (V), negative (N), zero (Z) and carry (C). Each operation defines its own subset of these flags. Any flag that an operation does not define, and always I and T, is copied from the incoming status byte. Compare operations update flags but raise no write strobe. Two word operations add or subtract the six-bit constant to or from a sixteen-bit register pair, presented as a low byte and a high byte.

Top module: `alu8_flags`

## Requirements
- R1: Outputs are registered: all of them are zero while `rst_n` is low, and the values for inputs presented before a rising edge appear after that edge. Operation codes: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 compare, 5 compare with carry, 6 AND, 7 OR, 8 XOR, 9 complement, 10 negate, 11 increment, 12 decrement, 13 logical right shift, 14 arithmetic right shift, 15 rotate right through carry, 16 nibble swap, 17 word add of constant, 18 word subtract of constant. Status bit positions: I 7, T 6, H 5, S 4, V 3, N 2, Z 1, C 0.
- R2: Add and add with carry (carry in is status bit 0) form r = a + b + cin; with g = (a&b)|(a&~r)|(b&~r), H = g[3], C = g[7], V = bit 7 of (a&b&~r)|(~a&~b&r), N = r[7], S = N^V, Z = (r == 0).
- R3: Subtract forms r = a - b; with g = (~a&b)|(b&r)|(r&~a), H = g[3], C = g[7], V = bit 7 of (a&~b&~r)|(~a&b&r), N = r[7], S = N^V, Z = (r == 0).
- R4: Subtract with carry and compare with carry subtract carry in as well and set Z only when the result is zero and Z was already set in the incoming status byte.
- R5: Compare and compare with carry give the same flags and result as the matching subtract, with the write strobe low; every other defined code raises the write strobe.
- R6: AND, OR and XOR clear V, set N and S from result bit 7 and Z from a zero result, and keep H and C; complement gives ~a with the same flags except that C is forced to 1.
- R7: Negate gives r = 0 - a, C = (r != 0), Z = (r == 0), V = (r == 0x80), N = r[7], S = N^V, H = bit 3 of (r | a).
- R8: Increment sets V for a result of 0x80, decrement sets V for a result of 0x7F; both set N = r[7], S = N^V, Z from a zero result, and keep H and C.
- R9: Right shifts place a[0] in C and shift a right by one; bit 7 becomes 0 (logical), a[7] (arithmetic) or the incoming C (rotate). N = r[7], V = N^C, S = N^V, Z from a zero result, H kept.
- R10: Nibble swap returns {a[3:0], a[7:4]} and leaves the whole status byte unchanged.
- R11: Word operations act on w = {b, a} with the zero-extended constant; N = r[15], Z = (r == 0), S = N^V, H kept; for add C = ~r[15]&w[15], V = r[15]&~w[15]; for subtract C = r[15]&~w[15], V = ~r[15]&w[15]. The result high byte is zero for byte operations, and the pair index output is 24 + 2*pair_sel.
- R12: I and T always pass through; an undefined code (19 to 31) gives result zero, write strobe low and the incoming status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 5 | Operation code |
| opd_a | input | 8 | First operand, or low byte of the pair |
| opd_b | input | 8 | Second operand, or high byte of the pair |
| imm6 | input | 6 | Constant for the word operations |
| pair_sel | input | 2 | Register pair selector |
| status_in | input | 8 | Current status byte |
| result_lo | output | 8 | Result byte, or low byte of a word result |
| result_hi | output | 8 | High byte of a word result |
| write_en | output | 1 | Result should be written back |
| pair_index | output | 5 | Register number of the selected pair's low byte |
| status_out | output | 8 | Next status byte |

## Verification
The assertions watch, on every cycle, the rules that hold for a whole class of operations: I and T passing through, compares never writing, swap leaving the flags alone, the chained subtract never raising Z, the shift overflow rule, increment and decrement keeping carry, and the output registers following the next-state logic by one cycle. The exact numeric results and flag values for particular operands, such as the half carry of an add, the 0x80 corner of negate or the wrap of a word add through zero, can only be shown by the bench's vectors with hand-worked expected values.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int DW = 8;
  localparam int WW = 2 * DW;
  localparam int OPW = 5;
  localparam int KW = 6;
  localparam int PSW = 2;
  localparam int PIW = 5;
  localparam int PAIR_BASE = 24;

  localparam int FB_I = 7;
  localparam int FB_T = 6;
  localparam int FB_H = 5;
  localparam int FB_S = 4;
  localparam int FB_V = 3;
  localparam int FB_N = 2;
  localparam int FB_Z = 1;
  localparam int FB_C = 0;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_CMP  = 5'd4,
    OP_CMPC = 5'd5,
    OP_AND  = 5'd6,
    OP_OR   = 5'd7,
    OP_XOR  = 5'd8,
    OP_COM  = 5'd9,
    OP_NEG  = 5'd10,
    OP_INC  = 5'd11,
    OP_DEC  = 5'd12,
    OP_SHR  = 5'd13,
    OP_SAR  = 5'd14,
    OP_RRC  = 5'd15,
    OP_SWAP = 5'd16,
    OP_WADD = 5'd17,
    OP_WSUB = 5'd18
  } alu_op_e;

  // Returns {half, overflow, carry} for r = a + b (+ cin).
  function automatic logic [2:0] add_hvc(input logic [DW-1:0] a,
                                         input logic [DW-1:0] b,
                                         input logic [DW-1:0] r);
    logic [DW-1:0] cv;
    logic [DW-1:0] ov;
    cv = (a & b) | (a & ~r) | (b & ~r);
    ov = (a & b & ~r) | (~a & ~b & r);
    return {cv[3], ov[DW-1], cv[DW-1]};
  endfunction

  // Returns {half, overflow, borrow} for r = a - b (- cin).
  function automatic logic [2:0] sub_hvc(input logic [DW-1:0] a,
                                         input logic [DW-1:0] b,
                                         input logic [DW-1:0] r);
    logic [DW-1:0] bv;
    logic [DW-1:0] ov;
    bv = (~a & b) | (b & r) | (r & ~a);
    ov = (a & ~b & ~r) | (~a & b & r);
    return {bv[3], ov[DW-1], bv[DW-1]};
  endfunction

endpackage

// File: rtl/alu8_byte_ops.sv
module alu8_byte_ops
  import alu8_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  input  logic [DW-1:0]  sin,
  output logic [DW-1:0]  res,
  output logic           we,
  output logic [DW-1:0]  sout,
  output logic           chain_sub,
  output logic           res_zero
);

  logic [2:0]    hvc;
  logic          cin;
  logic          top_bit;
  logic          nflag;
  logic          vflag;

  assign chain_sub = (op == OP_SBC) || (op == OP_CMPC);
  assign res_zero  = (res == '0);

  always_comb begin
    res     = '0;
    we      = 1'b0;
    sout    = sin;
    hvc     = '0;
    cin     = 1'b0;
    top_bit = 1'b0;
    nflag   = 1'b0;
    vflag   = 1'b0;
    case (op)
      OP_ADD, OP_ADC: begin
        cin  = (op == OP_ADC) ? sin[FB_C] : 1'b0;
        res  = a + b + {{(DW-1){1'b0}}, cin};
        hvc  = add_hvc(a, b, res);
        we   = 1'b1;
        sout[FB_H] = hvc[2];
        sout[FB_V] = hvc[1];
        sout[FB_C] = hvc[0];
        sout[FB_N] = res[DW-1];
        sout[FB_S] = res[DW-1] ^ hvc[1];
        sout[FB_Z] = (res == '0);
      end
      OP_SUB, OP_SBC, OP_CMP, OP_CMPC: begin
        cin  = (op == OP_SBC || op == OP_CMPC) ? sin[FB_C] : 1'b0;
        res  = a - b - {{(DW-1){1'b0}}, cin};
        hvc  = sub_hvc(a, b, res);
        we   = (op == OP_SUB) || (op == OP_SBC);
        sout[FB_H] = hvc[2];
        sout[FB_V] = hvc[1];
        sout[FB_C] = hvc[0];
        sout[FB_N] = res[DW-1];
        sout[FB_S] = res[DW-1] ^ hvc[1];
        sout[FB_Z] = (op == OP_SBC || op == OP_CMPC) ?
                     ((res == '0) && sin[FB_Z]) : (res == '0);
      end
      OP_AND, OP_OR, OP_XOR, OP_COM: begin
        case (op)
          OP_AND:  res = a & b;
          OP_OR:   res = a | b;
          OP_XOR:  res = a ^ b;
          default: res = ~a;
        endcase
        we = 1'b1;
        sout[FB_V] = 1'b0;
        sout[FB_N] = res[DW-1];
        sout[FB_S] = res[DW-1];
        sout[FB_Z] = (res == '0);
        if (op == OP_COM) sout[FB_C] = 1'b1;
      end
      OP_NEG: begin
        res   = '0 - a;
        we    = 1'b1;
        vflag = (res == {1'b1, {(DW-1){1'b0}}});
        sout[FB_C] = (res != '0);
        sout[FB_Z] = (res == '0);
        sout[FB_V] = vflag;
        sout[FB_N] = res[DW-1];
        sout[FB_S] = res[DW-1] ^ vflag;
        sout[FB_H] = res[3] | a[3];
      end
      OP_INC, OP_DEC: begin
        res   = (op == OP_INC) ? a + 1'b1 : a - 1'b1;
        we    = 1'b1;
        vflag = (op == OP_INC) ? (res == {1'b1, {(DW-1){1'b0}}})
                               : (res == {1'b0, {(DW-1){1'b1}}});
        sout[FB_V] = vflag;
        sout[FB_N] = res[DW-1];
        sout[FB_S] = res[DW-1] ^ vflag;
        sout[FB_Z] = (res == '0);
      end
      OP_SHR, OP_SAR, OP_RRC: begin
        case (op)
          OP_SHR:  top_bit = 1'b0;
          OP_SAR:  top_bit = a[DW-1];
          default: top_bit = sin[FB_C];
        endcase
        res   = {top_bit, a[DW-1:1]};
        we    = 1'b1;
        nflag = res[DW-1];
        vflag = nflag ^ a[0];
        sout[FB_C] = a[0];
        sout[FB_N] = nflag;
        sout[FB_V] = vflag;
        sout[FB_S] = nflag ^ vflag;
        sout[FB_Z] = (res == '0);
      end
      OP_SWAP: begin
        res = {a[DW/2-1:0], a[DW-1:DW/2]};
        we  = 1'b1;
      end
      default: begin
        res = '0;
        we  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alu8_word_ops.sv
module alu8_word_ops
  import alu8_pkg::*;
(
  input  logic           is_sub,
  input  logic [DW-1:0]  lo,
  input  logic [DW-1:0]  hi,
  input  logic [KW-1:0]  k,
  input  logic [DW-1:0]  sin,
  output logic [WW-1:0]  wres,
  output logic [DW-1:0]  sout
);

  logic [WW-1:0] w_old;
  logic [WW-1:0] k_ext;
  logic          msb_old;
  logic          msb_new;
  logic          cflag;
  logic          vflag;

  assign w_old   = {hi, lo};
  assign k_ext   = {{(WW-KW){1'b0}}, k};
  assign wres    = is_sub ? (w_old - k_ext) : (w_old + k_ext);
  assign msb_old = w_old[WW-1];
  assign msb_new = wres[WW-1];
  assign cflag   = is_sub ? (msb_new & ~msb_old) : (~msb_new & msb_old);
  assign vflag   = is_sub ? (~msb_new & msb_old) : (msb_new & ~msb_old);

  always_comb begin
    sout       = sin;
    sout[FB_C] = cflag;
    sout[FB_V] = vflag;
    sout[FB_N] = msb_new;
    sout[FB_S] = msb_new ^ vflag;
    sout[FB_Z] = (wres == '0);
  end

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPW-1:0]   op_code,
  input  logic [DW-1:0]    opd_a,
  input  logic [DW-1:0]    opd_b,
  input  logic [KW-1:0]    imm6,
  input  logic [PSW-1:0]   pair_sel,
  input  logic [DW-1:0]    status_in,
  output logic [DW-1:0]    result_lo,
  output logic [DW-1:0]    result_hi,
  output logic             write_en,
  output logic [PIW-1:0]   pair_index,
  output logic [DW-1:0]    status_out
);

  logic [DW-1:0]  b_res;
  logic           b_we;
  logic [DW-1:0]  b_status;
  logic           chain_sub;
  logic           res_zero;
  logic [WW-1:0]  w_res;
  logic [DW-1:0]  w_status;
  logic           is_word;

  logic [DW-1:0]  nxt_lo;
  logic [DW-1:0]  nxt_hi;
  logic           nxt_we;
  logic [DW-1:0]  nxt_status;
  logic [PIW-1:0] nxt_pair;

  alu8_byte_ops u_byte (
    .op        (op_code),
    .a         (opd_a),
    .b         (opd_b),
    .sin       (status_in),
    .res       (b_res),
    .we        (b_we),
    .sout      (b_status),
    .chain_sub (chain_sub),
    .res_zero  (res_zero)
  );

  alu8_word_ops u_word (
    .is_sub (op_code == OP_WSUB),
    .lo     (opd_a),
    .hi     (opd_b),
    .k      (imm6),
    .sin    (status_in),
    .wres   (w_res),
    .sout   (w_status)
  );

  assign is_word    = (op_code == OP_WADD) || (op_code == OP_WSUB);
  assign nxt_lo     = is_word ? w_res[DW-1:0] : b_res;
  assign nxt_hi     = is_word ? w_res[WW-1:DW] : '0;
  assign nxt_we     = is_word | b_we;
  assign nxt_status = is_word ? w_status : b_status;
  assign nxt_pair   = PIW'(PAIR_BASE) + {{(PIW-PSW-1){1'b0}}, pair_sel, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_lo  <= '0;
      result_hi  <= '0;
      write_en   <= 1'b0;
      pair_index <= '0;
      status_out <= '0;
    end else begin
      result_lo  <= nxt_lo;
      result_hi  <= nxt_hi;
      write_en   <= nxt_we;
      pair_index <= nxt_pair;
      status_out <= nxt_status;
    end
  end

endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk
  import alu8_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic [OPW-1:0] op_code,
  input logic [DW-1:0]  status_in,
  input logic [DW-1:0]  nxt_status,
  input logic           nxt_we,
  input logic           chain_sub,
  input logic           res_zero,
  input logic [DW-1:0]  status_out,
  input logic           write_en
);

  logic primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  assert_it_pass_R12: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_status[FB_I:FB_T] == status_in[FB_I:FB_T]);

  assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_CMP || op_code == OP_CMPC) |-> !nxt_we);

  assert_swap_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_SWAP) |-> (nxt_status == status_in));

  assert_chain_z_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_sub && (!status_in[FB_Z] || !res_zero)) |-> !nxt_status[FB_Z]);

  assert_shift_v_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_SHR || op_code == OP_SAR || op_code == OP_RRC) |->
    (nxt_status[FB_V] == (nxt_status[FB_N] ^ nxt_status[FB_C])));

  assert_incdec_c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_INC || op_code == OP_DEC) |->
    (nxt_status[FB_C] == status_in[FB_C] && nxt_status[FB_H] == status_in[FB_H]));

  assert_reg_stage_R1: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (status_out == $past(nxt_status) && write_en == $past(nxt_we)));

endmodule

bind alu8_flags alu8_flags_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_code    (op_code),
  .status_in  (status_in),
  .nxt_status (nxt_status),
  .nxt_we     (nxt_we),
  .chain_sub  (chain_sub),
  .res_zero   (res_zero),
  .status_out (status_out),
  .write_en   (write_en)
);

// File: tb/alu8_flags_tb.sv
module alu8_flags_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 26;

  // {op, a, b, status_in, exp_result, exp_we, exp_status}
  localparam logic [45:0] VEC [NV] = '{
    {5'd0,  8'h0F, 8'h01, 8'h00, 8'h10, 1'b1, 8'h20},  // R2 half carry
    {5'd0,  8'h7F, 8'h01, 8'hC0, 8'h80, 1'b1, 8'hEC},  // R2 overflow, I/T kept
    {5'd1,  8'hFF, 8'h00, 8'h01, 8'h00, 1'b1, 8'h23},  // R2 carry in
    {5'd2,  8'h10, 8'h01, 8'h00, 8'h0F, 1'b1, 8'h20},  // R3 half borrow
    {5'd2,  8'h05, 8'h05, 8'h00, 8'h00, 1'b1, 8'h02},  // R3 zero
    {5'd2,  8'h00, 8'h01, 8'h00, 8'hFF, 1'b1, 8'h35},  // R3 borrow
    {5'd3,  8'h05, 8'h04, 8'h01, 8'h00, 1'b1, 8'h00},  // R4 Z not kept
    {5'd3,  8'h05, 8'h04, 8'h03, 8'h00, 1'b1, 8'h02},  // R4 Z kept
    {5'd5,  8'h80, 8'h01, 8'h02, 8'h7F, 1'b0, 8'h38},  // R5 R4 compare with carry
    {5'd4,  8'h33, 8'h33, 8'h01, 8'h00, 1'b0, 8'h02},  // R5 compare equal
    {5'd6,  8'hF0, 8'h8F, 8'h29, 8'h80, 1'b1, 8'h35},  // R6 AND keeps H,C
    {5'd7,  8'h00, 8'h00, 8'h08, 8'h00, 1'b1, 8'h02},  // R6 OR zero
    {5'd8,  8'hAA, 8'hFF, 8'h40, 8'h55, 1'b1, 8'h40},  // R6 XOR
    {5'd9,  8'h00, 8'h00, 8'h00, 8'hFF, 1'b1, 8'h15},  // R6 complement C
    {5'd10, 8'h01, 8'h00, 8'h00, 8'hFF, 1'b1, 8'h35},  // R7
    {5'd10, 8'h80, 8'h00, 8'h10, 8'h80, 1'b1, 8'h0D},  // R7 0x80
    {5'd10, 8'h00, 8'h00, 8'hFF, 8'h00, 1'b1, 8'hC2},  // R7 zero
    {5'd11, 8'h7F, 8'h00, 8'h01, 8'h80, 1'b1, 8'h0D},  // R8 inc 0x80
    {5'd11, 8'hFF, 8'h00, 8'h20, 8'h00, 1'b1, 8'h22},  // R8 inc wrap
    {5'd12, 8'h80, 8'h00, 8'h00, 8'h7F, 1'b1, 8'h18},  // R8 dec 0x7F
    {5'd12, 8'h01, 8'h00, 8'h01, 8'h00, 1'b1, 8'h03},  // R8 dec zero keeps C
    {5'd13, 8'h01, 8'h00, 8'h00, 8'h00, 1'b1, 8'h1B},  // R9 logical
    {5'd14, 8'h81, 8'h00, 8'h00, 8'hC0, 1'b1, 8'h15},  // R9 arithmetic
    {5'd15, 8'h02, 8'h00, 8'h01, 8'h81, 1'b1, 8'h0C},  // R9 rotate
    {5'd16, 8'h3C, 8'h00, 8'hA5, 8'hC3, 1'b1, 8'hA5},  // R10 swap
    {5'd31, 8'h12, 8'h34, 8'h5A, 8'h00, 1'b0, 8'h5A}   // R12 undefined code
  };

  logic       clk;
  logic       rst_n;
  logic [4:0] op_code;
  logic [7:0] opd_a;
  logic [7:0] opd_b;
  logic [5:0] imm6;
  logic [1:0] pair_sel;
  logic [7:0] status_in;
  logic [7:0] result_lo;
  logic [7:0] result_hi;
  logic       write_en;
  logic [4:0] pair_index;
  logic [7:0] status_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  alu8_flags u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_code    (op_code),
    .opd_a      (opd_a),
    .opd_b      (opd_b),
    .imm6       (imm6),
    .pair_sel   (pair_sel),
    .status_in  (status_in),
    .result_lo  (result_lo),
    .result_hi  (result_hi),
    .write_en   (write_en),
    .pair_index (pair_index),
    .status_out (status_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [5:0] k, input logic [1:0] ps, input logic [7:0] s);
    @(negedge clk);
    op_code = op; opd_a = a; opd_b = b; imm6 = k; pair_sel = ps; status_in = s;
    @(negedge clk);
  endtask

  task automatic word_case(input string req, input logic [4:0] op, input logic [15:0] w,
                           input logic [5:0] k, input logic [7:0] s,
                           input logic [15:0] er, input logic [7:0] es);
    apply(op, w[7:0], w[15:8], k, 2'd2, s);
    check(req, {result_hi, result_lo}, er);
    check(req, status_out, es);
    check(req, write_en, 1'b1);
    check(req, pair_index, 5'd28);
  endtask

  initial begin
    rst_n = 1'b0;
    op_code = 5'd0; opd_a = 8'h55; opd_b = 8'h66; imm6 = 6'd9;
    pair_sel = 2'd1; status_in = 8'hFF;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", {result_hi, result_lo, 7'd0, write_en, 3'd0, pair_index}, 32'h0);
    check("R1 reset status", status_out, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][45:41], VEC[i][40:33], VEC[i][32:25], 6'd0, 2'd0, VEC[i][24:17]);
      check($sformatf("R1 vector %0d result", i), result_lo, VEC[i][16:9]);
      check($sformatf("R5 vector %0d write", i), write_en, VEC[i][8]);
      check($sformatf("R12 vector %0d status", i), status_out, VEC[i][7:0]);
      check($sformatf("R11 vector %0d high byte", i), result_hi, 8'h00);
    end

    // R11 word operations
    word_case("R11 add to 0x8000", 5'd17, 16'h7FFF, 6'd1,  8'h00, 16'h8000, 8'h0C);
    word_case("R11 add wraps",     5'd17, 16'hFFC1, 6'h3F, 8'h00, 16'h0000, 8'h03);
    word_case("R11 sub wraps",     5'd18, 16'h0000, 6'd1,  8'h20, 16'hFFFF, 8'h35);
    word_case("R11 sub overflow",  5'd18, 16'h8000, 6'd1,  8'hC0, 16'h7FFF, 8'hD8);
    apply(5'd6, 8'h01, 8'h01, 6'd0, 2'd3, 8'h00);
    check("R11 pair index 30", pair_index, 5'd30);

    // R1 registered timing: output only changes after the edge
    @(negedge clk);
    op_code = 5'd11; opd_a = 8'h41; status_in = 8'h00;
    #1;
    check("R1 held before edge", result_lo, 8'h01);
    @(negedge clk);
    check("R1 updated after edge", result_lo, 8'h42);

    // R1 reset mid-run clears outputs
    rst_n = 1'b0;
    #1;
    check("R1 async reset", {result_lo, status_out}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule